// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of an asynchronous serial port. The transmit and receive engines send it one-cycle event pulses. It turns each pulse into a sticky flag and keeps that flag until software or a data-transfer controller clears it by the permitted route. The flags also leave the block as level interrupt sources. The same register carries the multiprocessor bit of the most recently accepted received frame, plus a software-owned bit that chooses the multiprocessor bit of the next transmitted frame.

Software cannot clear a flag just by writing 0 to it. First it must read the register while that flag is 1. This arms the flag, and only an armed flag is cleared by a later write of 0 to its bit. The arm is tracked separately for each flag. If hardware sets the flag again before the write arrives, the arm is lost. A data-transfer controller can also retire the transmit-empty, transmit-end and receive-full flags when it moves data. It may do so only while its disable-select is low and its transfer count is nonzero.

Top module: `sio_status_reg`

## Requirements
- R1: After reset the readback is 8'h84, irqTxEmpty and irqTxEnd are 1, irqRxFull, irqRxErr and mpTxBit are 0.
- R2: Readback bit positions: 7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-end, 1 received multiprocessor bit, 0 transmit multiprocessor bit.
- R3: A write of 0 clears bit 7, 6, 5, 4 or 3 only if that flag was armed by an earlier read that returned it as 1. Without that read, a write of 0 leaves the flag unchanged, and a write of 1 to these bits never has any effect. Any register write consumes all arms.
- R4: A hardware set of a flag cancels that flag's arm. When a set and a clear of a flag fall in the same cycle, the set wins.
- R5: Transmit-empty is set while txEnable is 0 and on a txLoad pulse. Transmit-end is set while txEnable is 0 and on a txLastBit pulse that arrives while transmit-empty is 1. Every clear of transmit-empty, whether by software or by the controller, also clears transmit-end.
- R6: An rxDone pulse that arrives while receive-full is 0 is an accepted frame. It sets receive-full only if rxStop is 1 and the parity is good. An rxDone pulse that arrives while receive-full is 1 sets overrun and changes nothing else.
- R7: On an accepted frame, rxStop = 0 sets framing error. A parity error is set when the count of 1s in rxData and rxParity is odd with parityOdd = 0, or even with parityOdd = 1.
- R8: Bit 1 takes rxMpBit on every accepted frame. Writes to bits 2 and 1 are ignored.
- R9: Bit 0 is read/write, and it drives mpTxBit from the cycle after the write.
- R10: xferWrTx clears transmit-empty (and with it transmit-end), and xferRdRx clears receive-full. Each does so only when xferDisSel is 0 and xferCntNz is 1.
- R11: irqTxEmpty, irqRxFull and irqTxEnd equal bits 7, 6 and 2. irqRxErr is the OR of bits 5, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | CPU read strobe for the register |
| wrEn | input | 1 | CPU write strobe for the register |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | Register readback |
| txEnable | input | 1 | Transmitter enable |
| parityOdd | input | 1 | Parity mode: 1 odd, 0 even |
| txLoad | input | 1 | Pulse: transmit byte moved to shifter, data register free |
| txLastBit | input | 1 | Pulse: last bit of a character being sent |
| rxDone | input | 1 | Pulse: a received frame is complete |
| rxData | input | 8 | Received data byte |
| rxParity | input | 1 | Received parity bit |
| rxStop | input | 1 | Sampled stop bit |
| rxMpBit | input | 1 | Received multiprocessor bit |
| xferWrTx | input | 1 | Pulse: controller wrote the transmit data register |
| xferRdRx | input | 1 | Pulse: controller read the receive data register |
| xferDisSel | input | 1 | Controller disable-select |
| xferCntNz | input | 1 | Controller transfer count is nonzero |
| irqTxEmpty | output | 1 | Transmit-empty interrupt level |
| irqRxFull | output | 1 | Receive-full interrupt level |
| irqRxErr | output | 1 | Receive-error interrupt level |
| irqTxEnd | output | 1 | Transmit-end interrupt level |
| mpTxBit | output | 1 | Multiprocessor bit for the next transmitted frame |

## Verification
A wrong arm bit shows as a flag that survives its clearing write, or one that disappears without a preceding read. Either shows up on the readback in the cycle after that write. A faulty parity or stop decision, or faulty overrun routing, puts wrong bits 6 to 3 and a wrong irqRxErr in the cycle right after the rxDone pulse. The bench therefore sweeps every data byte, parity bit, parity mode and stop value, and compares that cycle with values it computes itself. A broken controller gate leaves transmit-empty or receive-full in the wrong state one cycle after the transfer pulse.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_TXE = 7;
  localparam int BIT_RXF = 6;
  localparam int BIT_OVR = 5;
  localparam int BIT_FRM = 4;
  localparam int BIT_PAR = 3;
  localparam int BIT_TXD = 2;
  localparam int BIT_MPR = 1;
  localparam int BIT_MPT = 0;
  localparam int ARM_LO  = 3;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h84;

  typedef struct packed {
    logic [7:3] swClr;
    logic [7:2] hwSet;
    logic       dtcClrTx;
    logic       dtcClrRx;
    logic       rxMpLoad;
    logic       rxMpVal;
    logic       mpTxWr;
    logic       mpTxVal;
  } stat_strobe_t;
endpackage

// File: rtl/sio_stat_ctrl.sv
module sio_stat_ctrl
  import sio_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic [7:2]        flagsIn,
  input  logic              txEnable,
  input  logic              parityOdd,
  input  logic              txLoad,
  input  logic              txLastBit,
  input  logic              rxDone,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParity,
  input  logic              rxStop,
  input  logic              rxMpBit,
  input  logic              xferWrTx,
  input  logic              xferRdRx,
  input  logic              xferDisSel,
  input  logic              xferCntNz,
  output stat_strobe_t      stb
);
  logic [7:2] hwSetV;
  logic [7:3] swClrV;
  logic [7:3] arm;
  logic [7:3] armNext;
  logic       rxAccept;
  logic       parityBad;
  logic       dtcOk;

  assign rxAccept  = rxDone && !flagsIn[BIT_RXF];
  assign parityBad = (^{rxData, rxParity}) != parityOdd;
  assign dtcOk     = !xferDisSel && xferCntNz;

  always_comb begin
    hwSetV          = '0;
    hwSetV[BIT_TXE] = !txEnable || txLoad;
    hwSetV[BIT_RXF] = rxAccept && rxStop && !parityBad;
    hwSetV[BIT_OVR] = rxDone && flagsIn[BIT_RXF];
    hwSetV[BIT_FRM] = rxAccept && !rxStop;
    hwSetV[BIT_PAR] = rxAccept && parityBad;
    hwSetV[BIT_TXD] = !txEnable || (txLastBit && flagsIn[BIT_TXE]);
  end

  for (genvar i = ARM_LO; i < REG_W; i++) begin : g_arm
    assign swClrV[i]  = wrEn && !wrData[i] && arm[i];
    assign armNext[i] = hwSetV[i] ? 1'b0 :
                        wrEn      ? 1'b0 :
                        rdEn      ? flagsIn[i] : arm[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) arm <= '0;
    else       arm <= armNext;
  end

  always_comb begin
    stb          = '0;
    stb.swClr    = swClrV;
    stb.hwSet    = hwSetV;
    stb.dtcClrTx = xferWrTx && dtcOk;
    stb.dtcClrRx = xferRdRx && dtcOk;
    stb.rxMpLoad = rxAccept;
    stb.rxMpVal  = rxMpBit;
    stb.mpTxWr   = wrEn;
    stb.mpTxVal  = wrData[BIT_MPT];
  end

  assert_txoff_R5: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (flagsIn[BIT_TXE] && flagsIn[BIT_TXD]));

  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && flagsIn[BIT_RXF]) |=> flagsIn[BIT_OVR]);

  assert_arm_cancel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hwSetV[7:3] != '0) |=> ((arm & $past(hwSetV[7:3])) == '0));

  assert_dtc_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((xferDisSel || !xferCntNz) && flagsIn[BIT_RXF] && !wrEn) |=> flagsIn[BIT_RXF]);
endmodule

// File: rtl/sio_stat_dp.sv
module sio_stat_dp
  import sio_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stat_strobe_t     stb,
  output logic [7:2]       flags,
  output logic [REG_W-1:0] rdData,
  output logic             mpTx,
  output logic             irqTxEmpty,
  output logic             irqRxFull,
  output logic             irqRxErr,
  output logic             irqTxEnd
);
  logic [7:2] clrV;
  logic [7:2] flagsNext;
  logic       mpRx;

  always_comb begin
    clrV          = '0;
    clrV[BIT_TXE] = stb.swClr[BIT_TXE] || stb.dtcClrTx;
    clrV[BIT_RXF] = stb.swClr[BIT_RXF] || stb.dtcClrRx;
    clrV[BIT_OVR] = stb.swClr[BIT_OVR];
    clrV[BIT_FRM] = stb.swClr[BIT_FRM];
    clrV[BIT_PAR] = stb.swClr[BIT_PAR];
    clrV[BIT_TXD] = stb.swClr[BIT_TXE] || stb.dtcClrTx;
  end

  for (genvar i = 2; i < REG_W; i++) begin : g_flag
    assign flagsNext[i] = stb.hwSet[i] ? 1'b1 :
                          clrV[i]      ? 1'b0 : flags[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= RESET_VAL[7:2];
      mpRx  <= RESET_VAL[BIT_MPR];
      mpTx  <= RESET_VAL[BIT_MPT];
    end else begin
      flags <= flagsNext;
      if (stb.rxMpLoad) mpRx <= stb.rxMpVal;
      if (stb.mpTxWr)   mpTx <= stb.mpTxVal;
    end
  end

  assign rdData     = {flags, mpRx, mpTx};
  assign irqTxEmpty = flags[BIT_TXE];
  assign irqRxFull  = flags[BIT_RXF];
  assign irqRxErr   = flags[BIT_OVR] | flags[BIT_FRM] | flags[BIT_PAR];
  assign irqTxEnd   = flags[BIT_TXD];

  assert_mptx_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.mpTxWr |=> (mpTx == $past(stb.mpTxVal)));

  assert_ovr_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags[BIT_OVR]) |-> $past(stb.swClr[BIT_OVR]));

  assert_frm_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags[BIT_FRM]) |-> $past(stb.swClr[BIT_FRM]));

  assert_par_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags[BIT_PAR]) |-> $past(stb.swClr[BIT_PAR]));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hwSet[BIT_TXE] && stb.swClr[BIT_TXE]) |=> flags[BIT_TXE]);
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
  import sio_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              txEnable,
  input  logic              parityOdd,
  input  logic              txLoad,
  input  logic              txLastBit,
  input  logic              rxDone,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParity,
  input  logic              rxStop,
  input  logic              rxMpBit,
  input  logic              xferWrTx,
  input  logic              xferRdRx,
  input  logic              xferDisSel,
  input  logic              xferCntNz,
  output logic              irqTxEmpty,
  output logic              irqRxFull,
  output logic              irqRxErr,
  output logic              irqTxEnd,
  output logic              mpTxBit
);
  stat_strobe_t stb;
  logic [7:2]   flags;

  sio_stat_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .flagsIn(flags), .txEnable(txEnable), .parityOdd(parityOdd),
    .txLoad(txLoad), .txLastBit(txLastBit), .rxDone(rxDone),
    .rxData(rxData), .rxParity(rxParity), .rxStop(rxStop),
    .rxMpBit(rxMpBit), .xferWrTx(xferWrTx), .xferRdRx(xferRdRx),
    .xferDisSel(xferDisSel), .xferCntNz(xferCntNz), .stb(stb)
  );

  sio_stat_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .flags(flags), .rdData(rdData),
    .mpTx(mpTxBit), .irqTxEmpty(irqTxEmpty), .irqRxFull(irqRxFull),
    .irqRxErr(irqRxErr), .irqTxEnd(irqTxEnd)
  );
endmodule

// File: tb/test_sio_status_reg.sv
`timescale 1ns/1ps
module test_sio_status_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 0, wrEn = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic txEnable = 0, parityOdd = 0, txLoad = 0, txLastBit = 0;
  logic rxDone = 0, rxParity = 0, rxStop = 1, rxMpBit = 0;
  logic [7:0] rxData = '0;
  logic xferWrTx = 0, xferRdRx = 0, xferDisSel = 0, xferCntNz = 1;
  logic irqTxEmpty, irqRxFull, irqRxErr, irqTxEnd, mpTxBit;
  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  sio_status_reg i_sio_status_reg (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .txEnable(txEnable), .parityOdd(parityOdd),
    .txLoad(txLoad), .txLastBit(txLastBit), .rxDone(rxDone),
    .rxData(rxData), .rxParity(rxParity), .rxStop(rxStop),
    .rxMpBit(rxMpBit), .xferWrTx(xferWrTx), .xferRdRx(xferRdRx),
    .xferDisSel(xferDisSel), .xferCntNz(xferCntNz),
    .irqTxEmpty(irqTxEmpty), .irqRxFull(irqRxFull), .irqRxErr(irqRxErr),
    .irqTxEnd(irqTxEnd), .mpTxBit(mpTxBit)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] irqOf(input logic [7:0] r);
    return {4'b0, r[7], r[6], |r[5:3], r[2]};
  endfunction

  task automatic cpuRead(output logic [7:0] v);
    @(negedge clk); rdEn = 1; v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic cpuWrite(input logic [7:0] v);
    @(negedge clk); wrEn = 1; wrData = v;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rxFrame(input logic [7:0] d, input logic p, input logic s, input logic mp);
    @(negedge clk); rxDone = 1; rxData = d; rxParity = p; rxStop = s; rxMpBit = mp;
    @(negedge clk); rxDone = 0;
  endtask

  task automatic clearAll();
    logic [7:0] t;
    cpuRead(t);
    cpuWrite(8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 readback", rdData, 8'h84);
    check("R1 irq", {4'b0, irqTxEmpty, irqRxFull, irqRxErr, irqTxEnd}, 8'h09);
    check("R1 mpTxBit", {7'b0, mpTxBit}, 8'h00);

    // R9 bit0 read/write; R3 writes of 1 without read have no effect
    cpuWrite(8'hFF);
    check("R9 R3 write ones", rdData, 8'h85);
    check("R9 mpTxBit set", {7'b0, mpTxBit}, 8'h01);
    cpuWrite(8'h00);
    check("R9 mpTxBit clear", {7'b0, mpTxBit}, 8'h00);

    // R7 R6 R11 R2 sweep over all data, parity bit, mode, stop (txEnable=0)
    for (int d = 0; d < 256; d++) begin
      for (int pm = 0; pm < 8; pm++) begin
        logic p, m, s, perr, ferr;
        logic [7:0] exp;
        p = pm[0]; m = pm[1]; s = pm[2];
        parityOdd = m;
        perr = ($countones({d[7:0], p}) % 2) != int'(m);
        ferr = !s;
        rxFrame(d[7:0], p, s, 1'b0);
        exp = 8'h84 | ((!perr && !ferr) ? 8'h40 : 8'h00)
                    | (ferr ? 8'h10 : 8'h00) | (perr ? 8'h08 : 8'h00);
        check("R7 R6 frame flags", rdData, exp);
        check("R11 irq levels", {4'b0, irqTxEmpty, irqRxFull, irqRxErr, irqTxEnd}, irqOf(exp));
        clearAll();
        check("R3 clear after frame", rdData, 8'h84);
      end
    end
    parityOdd = 0;

    // R6 overrun, R8 multiprocessor bit
    rxFrame(8'h00, 1'b0, 1'b1, 1'b1);
    check("R8 R6 accepted mp=1", rdData, 8'hC6);
    rxFrame(8'h00, 1'b0, 1'b1, 1'b0);
    check("R6 overrun", rdData, 8'hE6);
    check("R11 overrun irq", {7'b0, irqRxErr}, 8'h01);
    clearAll();
    check("R8 mp held across overrun", rdData, 8'h86);
    cpuWrite(8'h00);
    check("R8 bits 2,1 ignore writes", rdData, 8'h86);
    rxFrame(8'h00, 1'b0, 1'b1, 1'b0);
    check("R8 mp copy 0", rdData, 8'hC4);
    clearAll();
    check("R3 clear rx", rdData, 8'h84);

    // transmit flags with txEnable=1
    @(negedge clk); txEnable = 1;
    cpuWrite(8'h00);
    check("R3 no read no clear", rdData, 8'h84);
    clearAll();
    check("R3 R5 read then write clears TDRE and TEND", rdData, 8'h00);
    @(negedge clk); txLastBit = 1; @(negedge clk); txLastBit = 0;
    check("R5 lastbit with TDRE=0", rdData, 8'h00);
    @(negedge clk); txLoad = 1; @(negedge clk); txLoad = 0;
    check("R5 txLoad sets TDRE", rdData, 8'h80);
    @(negedge clk); txLastBit = 1; @(negedge clk); txLastBit = 0;
    check("R5 lastbit with TDRE=1", rdData, 8'h84);

    // R4 arm cancelled by re-set
    cpuRead(rv);
    @(negedge clk); txLoad = 1; @(negedge clk); txLoad = 0;
    cpuWrite(8'h00);
    check("R4 arm cancelled", rdData, 8'h84);
    // R4 set wins over same-cycle clear
    cpuRead(rv);
    @(negedge clk); wrEn = 1; wrData = 8'h00; txLoad = 1;
    @(negedge clk); wrEn = 0; txLoad = 0;
    check("R4 set wins", rdData, 8'h80);
    clearAll();
    check("R3 clear TDRE", rdData, 8'h00);

    // R10 controller clear gating
    @(negedge clk); txLoad = 1; @(negedge clk); txLoad = 0;
    @(negedge clk); txLastBit = 1; @(negedge clk); txLastBit = 0;
    @(negedge clk); xferDisSel = 1; xferWrTx = 1; @(negedge clk); xferWrTx = 0;
    check("R10 disSel blocks tx clear", rdData, 8'h84);
    @(negedge clk); xferDisSel = 0; xferCntNz = 0; xferWrTx = 1; @(negedge clk); xferWrTx = 0;
    check("R10 zero count blocks tx clear", rdData, 8'h84);
    @(negedge clk); xferCntNz = 1; xferWrTx = 1; @(negedge clk); xferWrTx = 0;
    check("R10 tx clear", rdData, 8'h00);
    rxFrame(8'h01, 1'b1, 1'b1, 1'b0);
    check("R6 rx full", rdData, 8'h40);
    @(negedge clk); xferDisSel = 1; xferRdRx = 1; @(negedge clk); xferRdRx = 0;
    check("R10 disSel blocks rx clear", rdData, 8'h40);
    @(negedge clk); xferDisSel = 0; xferRdRx = 1; @(negedge clk); xferRdRx = 0;
    check("R10 rx clear", rdData, 8'h00);

    @(negedge clk); txEnable = 0;
    @(negedge clk);
    check("R5 txEnable low sets TDRE TEND", rdData, 8'h84);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule